// File: doc/BRIEF.md
# Two-Channel Fetch/Store DMA Engine

This block is a bus master with two independent copy channels. Each channel has its own source pointer, destination pointer, transfer count and control word. While a channel is enabled, has a nonzero count and sees its request line high, the engine takes the bus ahead of the processor. It then performs one transfer. A transfer is a read of the source into an internal holding register, followed by a write of that register to the destination. Either side may sit in memory space or in I/O space. The unit of a transfer is a byte or a 16-bit word.

Every bus cycle lasts `BUS_CLKS` clocks. A word whose address on one side is odd is moved on that side as two byte cycles: the low byte at the address, then the high byte at the address plus one. An even-aligned word needs only one read cycle and one write cycle. After each transfer the pointers step and the count drops by one. When the count reaches zero the channel disarms itself and raises its done flag. That flag can drive an interrupt line.

Top module: `dma2_engine`

## Requirements
- R1: After reset the bus is idle (`bus_cyc` low), every done and irq bit is 0, and a processor request is granted while no channel is pending.
- R2: Each transfer is a read cycle (`bus_wr`=0) at the source followed directly by a write cycle (`bus_wr`=1) at the destination, and the written data equal the bytes read.
- R3: Every bus cycle holds address, direction and space steady for `BUS_CLKS` (4) clocks. A byte transfer or an even-aligned word transfer uses exactly two bus cycles, and the first cycle begins one clock after the request is seen.
- R4: Control field [5:4] steps the source and [7:6] steps the destination after each transfer: 01 increments, 10 decrements, 00 and 11 hold. The step is 2 for words and 1 for bytes.
- R5: Register selects are 0 source, 1 destination, 2 count and 3 control. Control bit 0 arms the channel. Each transfer lowers the count by one. At zero the channel stops, its done bit sets, and irq equals done AND control bit 8. Writing control clears done. A disarmed channel runs no cycle.
- R6: The processor grant is high only while `cpu_req` is high, the engine is idle and no channel is pending. A pending channel starts its bus cycle on the next clock.
- R7: When both channels are pending, channel 0 is served first. The serving channel changes only between transfers.
- R8: For a word (control bit 1) with an odd address on one side, that side runs two byte cycles: the low byte at the address, then the high byte at the address plus one.
- R9: Control bit 2 puts the source in I/O space and bit 3 puts the destination there. `bus_io` follows the space of the side being accessed.
- R10: Byte accesses (`bus_word`=0) carry their data on bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Write data |
| drq | input | NCH | Per-channel transfer request level |
| cpu_req | input | 1 | Processor wants the bus |
| cpu_gnt | output | 1 | Processor may use the bus |
| bus_cyc | output | 1 | DMA bus cycle in progress |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_io | output | 1 | 1 I/O space, 0 memory space |
| bus_word | output | 1 | 1 word access, 0 byte access |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Store data |
| bus_rdata | input | 16 | Fetch data, sampled in the last clock of a read cycle |
| done | output | NCH | Per-channel count-exhausted flag |
| irq | output | NCH | Done flag gated by the interrupt enable |

## Verification
A request that is pending at a clock edge puts the read cycle on the bus right after that edge. The write cycle follows `BUS_CLKS` clocks later, and the bus falls idle `BUS_CLKS` clocks after that. Done and irq show their new values from the edge that closes the last write. The processor grant is combinational and answers within the same cycle. The bench drives inputs and samples outputs on falling edges and counts those edges from the request. It also totals the clocks with `bus_cyc` high and compares the total against the bus cycles implied by each vector's alignment.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

  typedef enum logic [2:0] {
    MV_IDLE,
    MV_FETCH_LO,
    MV_FETCH_HI,
    MV_STORE_LO,
    MV_STORE_HI
  } mv_state_e;

  // Control word, bit 0 at the bottom
  typedef struct packed {
    logic       irq_en;    // 8
    logic [1:0] dst_step;  // 7:6
    logic [1:0] src_step;  // 5:4
    logic       dst_io;    // 3
    logic       src_io;    // 2
    logic       word;      // 1
    logic       enable;    // 0
  } chan_ctrl_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // Pointer after one transfer: 01 up, 10 down, others hold
  function automatic logic [31:0] step_ptr(input logic [31:0] p,
                                           input logic [1:0]  code,
                                           input logic        word);
    logic [31:0] amt;
    amt = word ? 32'd2 : 32'd1;
    case (code)
      2'b01:   return p + amt;
      2'b10:   return p - amt;
      default: return p;
    endcase
  endfunction

  // A word on an odd address goes as two byte cycles
  function automatic logic needs_split(input logic word, input logic addr_lsb);
    return word & addr_lsb;
  endfunction

endpackage

// File: rtl/dma2_chan_regs.sv
module dma2_chan_regs
  import dma2_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          drq,
  input  logic          xfer_done,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output chan_ctrl_t    ctrl,
  output logic          pend,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      ctrl <= '0;
      done <= 1'b0;
    end else begin
      if (xfer_done) begin
        src <= AW'(step_ptr(32'(src), ctrl.src_step, ctrl.word));
        dst <= AW'(step_ptr(32'(dst), ctrl.dst_step, ctrl.word));
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          done        <= 1'b1;
          ctrl.enable <= 1'b0;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC: src <= wr_data;
          SEL_DST: dst <= wr_data;
          SEL_CNT: cnt <= wr_data[CW-1:0];
          default: begin
            ctrl <= chan_ctrl_t'(wr_data[8:0]);
            done <= 1'b0;
          end
        endcase
      end
    end
  end

  assign pend = ctrl.enable && (cnt != '0) && drq;

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  output logic [CHW-1:0] pick,
  output logic           any
);

  // Lowest channel index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = CHW'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/dma2_mover.sv
module dma2_mover
  import dma2_pkg::*;
#(
  parameter int AW       = 20,
  parameter int CHW      = 1,
  parameter int BUS_CLKS = 4,
  localparam int TW      = $clog2(BUS_CLKS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_pend,
  input  logic [CHW-1:0] pick,
  input  logic [AW-1:0]  cur_src,
  input  logic [AW-1:0]  cur_dst,
  input  chan_ctrl_t     cur_ctrl,
  input  logic [15:0]    bus_rdata,
  output logic [CHW-1:0] act_ch,
  output logic           idle,
  output logic           bus_last,
  output logic           xfer_end,
  output logic           bus_cyc,
  output logic           bus_wr,
  output logic           bus_io,
  output logic           bus_word,
  output logic [AW-1:0]  bus_addr,
  output logic [15:0]    bus_wdata
);

  mv_state_e state, state_nx;
  logic [TW-1:0] tick;
  logic [15:0]   hold;
  logic          src_split, dst_split;

  assign src_split = needs_split(cur_ctrl.word, cur_src[0]);
  assign dst_split = needs_split(cur_ctrl.word, cur_dst[0]);
  assign idle      = (state == MV_IDLE);
  assign bus_cyc   = !idle;
  assign bus_last  = bus_cyc && (tick == TW'(BUS_CLKS - 1));
  assign xfer_end  = bus_last && ((state == MV_STORE_LO && !dst_split) ||
                                  state == MV_STORE_HI);

  always_comb begin
    state_nx = state;
    case (state)
      MV_IDLE:     if (any_pend) state_nx = MV_FETCH_LO;
      MV_FETCH_LO: if (bus_last) state_nx = src_split ? MV_FETCH_HI : MV_STORE_LO;
      MV_FETCH_HI: if (bus_last) state_nx = MV_STORE_LO;
      MV_STORE_LO: if (bus_last) state_nx = dst_split ? MV_STORE_HI : MV_IDLE;
      MV_STORE_HI: if (bus_last) state_nx = MV_IDLE;
      default:     state_nx = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MV_IDLE;
      tick   <= '0;
      act_ch <= '0;
      hold   <= '0;
    end else begin
      state <= state_nx;
      if (idle) begin
        tick <= '0;
        if (any_pend) act_ch <= pick;
      end else begin
        tick <= bus_last ? '0 : tick + TW'(1);
      end
      if (bus_last && state == MV_FETCH_LO) begin
        if (cur_ctrl.word && !src_split) hold <= bus_rdata;
        else                             hold[7:0] <= bus_rdata[7:0];
      end
      if (bus_last && state == MV_FETCH_HI) hold[15:8] <= bus_rdata[7:0];
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_io    = 1'b0;
    bus_word  = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      MV_FETCH_LO: begin
        bus_io   = cur_ctrl.src_io;
        bus_word = cur_ctrl.word && !src_split;
        bus_addr = cur_src;
      end
      MV_FETCH_HI: begin
        bus_io   = cur_ctrl.src_io;
        bus_addr = cur_src + AW'(1);
      end
      MV_STORE_LO: begin
        bus_wr    = 1'b1;
        bus_io    = cur_ctrl.dst_io;
        bus_word  = cur_ctrl.word && !dst_split;
        bus_addr  = cur_dst;
        bus_wdata = bus_word ? hold : {8'h00, hold[7:0]};
      end
      MV_STORE_HI: begin
        bus_wr    = 1'b1;
        bus_io    = cur_ctrl.dst_io;
        bus_addr  = cur_dst + AW'(1);
        bus_wdata = {8'h00, hold[15:8]};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW       = 20,
  parameter int CW       = 16,
  parameter int NCH      = 2,
  parameter int BUS_CLKS = 4,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] drq,
  input  logic           cpu_req,
  output logic           cpu_gnt,
  output logic           bus_cyc,
  output logic           bus_wr,
  output logic           bus_io,
  output logic           bus_word,
  output logic [AW-1:0]  bus_addr,
  output logic [15:0]    bus_wdata,
  input  logic [15:0]    bus_rdata,
  output logic [NCH-1:0] done,
  output logic [NCH-1:0] irq
);

  logic [AW-1:0]  src_a  [NCH];
  logic [AW-1:0]  dst_a  [NCH];
  chan_ctrl_t     ctrl_a [NCH];
  logic [NCH-1:0] pend;
  logic [NCH-1:0] xfer_done;
  logic [CHW-1:0] pick, act_ch;
  logic           any_pend, mv_idle, bus_last, xfer_end;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign xfer_done[i] = xfer_end && (act_ch == CHW'(i));

    dma2_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_ch == CHW'(i))),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .drq       (drq[i]),
      .xfer_done (xfer_done[i]),
      .src       (src_a[i]),
      .dst       (dst_a[i]),
      .ctrl      (ctrl_a[i]),
      .pend      (pend[i]),
      .done      (done[i])
    );

    assign irq[i] = done[i] && ctrl_a[i].irq_en;
  end

  dma2_arb #(.NCH(NCH)) u_arb (
    .pend (pend),
    .pick (pick),
    .any  (any_pend)
  );

  dma2_mover #(.AW(AW), .CHW(CHW), .BUS_CLKS(BUS_CLKS)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_pend  (any_pend),
    .pick      (pick),
    .cur_src   (src_a[act_ch]),
    .cur_dst   (dst_a[act_ch]),
    .cur_ctrl  (ctrl_a[act_ch]),
    .bus_rdata (bus_rdata),
    .act_ch    (act_ch),
    .idle      (mv_idle),
    .bus_last  (bus_last),
    .xfer_end  (xfer_end),
    .bus_cyc   (bus_cyc),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  assign cpu_gnt = cpu_req && mv_idle && !any_pend;

endmodule

// File: rtl/dma2_engine_chk.sv
module dma2_engine_chk #(
  parameter int AW  = 20,
  parameter int NCH = 2,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_cyc,
  input logic           bus_wr,
  input logic           bus_io,
  input logic           bus_word,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_last,
  input logic [CHW-1:0] act_ch,
  input logic           any_pend,
  input logic [NCH-1:0] xfer_done
);

  AST_PEND_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pend && !bus_cyc) |=> bus_cyc); // R6

  AST_CH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> $stable(act_ch)); // R7

  AST_CYC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc) && !$past(bus_last))
      |-> ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_io))); // R3

  AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_cyc && !bus_wr)); // R2

  AST_SPLIT_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc) && $past(bus_last) && !bus_word &&
     !$past(bus_word) && (bus_wr == $past(bus_wr)))
      |-> (bus_addr == AW'($past(bus_addr) + AW'(1)))); // R8

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_done)); // R5

endmodule

bind dma2_engine dma2_engine_chk #(.AW(AW), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cyc   (bus_cyc),
  .bus_wr    (bus_wr),
  .bus_io    (bus_io),
  .bus_word  (bus_word),
  .bus_addr  (bus_addr),
  .bus_last  (bus_last),
  .act_ch    (act_ch),
  .any_pend  (any_pend),
  .xfer_done (xfer_done)
);

// File: tb/dma2_engine_test.sv
module dma2_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  typedef struct packed {
    logic [8:0]  ctrl;
    logic [19:0] src;
    logic [19:0] dst;
    logic [15:0] cnt;
    logic [15:0] clks;
  } vec_t;

  // ctrl: 1 arm, 2 word, 4 src io, 8 dst io, 10/20 src up/down, 40/80 dst up/down, 100 irq
  localparam vec_t VECS [6] = '{
    '{9'h151, 20'h10, 20'h80, 16'd3, 16'd24},  // bytes mem->mem, up/up
    '{9'h05B, 20'h20, 20'h40, 16'd2, 16'd16},  // even words mem->io
    '{9'h067, 20'h31, 20'h90, 16'd2, 16'd24},  // odd src word io->mem, down/up
    '{9'h143, 20'h50, 20'hA1, 16'd2, 16'd24},  // odd dst word, src hold
    '{9'h0AD, 20'h6F, 20'hEF, 16'd2, 16'd16},  // bytes io->io, down/down
    '{9'h0F3, 20'h61, 20'hC3, 16'd1, 16'd16}   // both odd, code 11 holds
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [0:0]    cfg_ch = '0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [1:0]    drq = '0;
  logic          cpu_req = 1'b1;
  logic          cpu_gnt, bus_cyc, bus_wr, bus_io, bus_word;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata, bus_rdata;
  logic [1:0]    done, irq;

  logic [7:0] mem  [512];
  logic [7:0] snap [512];
  int checks = 0;
  int errors = 0;
  int busclks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma2_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .drq(drq),
    .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .bus_cyc(bus_cyc),
    .bus_wr(bus_wr), .bus_io(bus_io), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .irq(irq)
  );

  // Memory and I/O model, indexed by {space, low address byte}
  assign bus_rdata = bus_word
    ? {mem[{bus_io, bus_addr[7:0] + 8'd1}], mem[{bus_io, bus_addr[7:0]}]}
    : {8'h00, mem[{bus_io, bus_addr[7:0]}]};

  always @(negedge clk) begin
    if (bus_cyc) busclks++;
    if (bus_cyc && bus_wr) begin
      mem[{bus_io, bus_addr[7:0]}] <= bus_wdata[7:0];
      if (bus_word) mem[{bus_io, bus_addr[7:0] + 8'd1}] <= bus_wdata[15:8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int nxt(input int a, input logic [1:0] code, input bit w);
    int n = w ? 2 : 1;
    if (code == 2'b01) return a + n;
    if (code == 2'b10) return a - n;
    return a;
  endfunction

  task automatic wait_done(input int ch);
    for (int t = 0; t < 400 && !done[ch]; t++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    int s, d, nb;
    snap = mem;
    busclks = 0;
    wr(0, 2'd0, v.src); wr(0, 2'd1, v.dst); wr(0, 2'd2, 20'(v.cnt)); wr(0, 2'd3, 20'(v.ctrl));
    drq[0] = 1'b1;
    wait_done(0);
    drq[0] = 1'b0;
    chk("R5 done after count", 32'(done[0]), 32'd1);
    chk("R5 irq gating", 32'(irq[0]), 32'(v.ctrl[8]));
    chk("R3/R8 bus clocks", 32'(busclks), 32'(v.clks));
    s = int'(v.src); d = int'(v.dst); nb = v.ctrl[1] ? 2 : 1;
    for (int k = 0; k < int'(v.cnt); k++) begin
      for (int b = 0; b < nb; b++)
        chk("R2/R4/R9/R10 copied byte", 32'(mem[{v.ctrl[3], 8'(d + b)}]),
            32'(snap[{v.ctrl[2], 8'(s + b)}]));
      s = nxt(s, v.ctrl[5:4], v.ctrl[1]);
      d = nxt(d, v.ctrl[7:6], v.ctrl[1]);
    end
    wr(0, 2'd3, '0);
    chk("R5 control write clears done", 32'(done[0]), 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus idle", 32'(bus_cyc), 32'd0);
    chk("R1 done clear", 32'(done), 32'd0);
    chk("R1 irq clear", 32'(irq), 32'd0);
    chk("R1 R6 cpu granted", 32'(cpu_gnt), 32'd1);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R5: disarmed channel with count and request does nothing
    wr(1, 2'd2, 20'd3);
    busclks = 0;
    drq[1] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 disarmed runs no cycle", 32'(busclks), 32'd0);
    drq[1] = 1'b0;

    // R2/R3/R6 cycle-exact single byte transfer
    wr(0, 2'd0, 20'h05); wr(0, 2'd1, 20'hB0); wr(0, 2'd2, 20'd1); wr(0, 2'd3, 20'h051);
    busclks = 0;
    @(negedge clk);
    drq[0] = 1'b1;
    #1;
    chk("R6 cpu locked out while pending", 32'(cpu_gnt), 32'd0);
    @(negedge clk);
    chk("R3 read starts next clock", 32'({bus_cyc, bus_wr}), 32'b10);
    chk("R2 read at source", bus_addr, 32'h05);
    repeat (4) @(negedge clk);
    chk("R2 R3 write after four clocks", 32'({bus_cyc, bus_wr}), 32'b11);
    chk("R2 write at destination", bus_addr, 32'hB0);
    chk("R10 byte on low lane", 32'(bus_wdata), 32'(mem[9'h005]));
    repeat (4) @(negedge clk);
    chk("R3 idle after two cycles", 32'(bus_cyc), 32'd0);
    chk("R5 done at end", 32'(done[0]), 32'd1);
    repeat (10) @(negedge clk);
    chk("R5 stops at zero", 32'(busclks), 32'd8);
    chk("R6 cpu regains bus", 32'(cpu_gnt), 32'd1);
    drq[0] = 1'b0;
    wr(0, 2'd3, '0);

    // R7 simultaneous requests
    wr(0, 2'd0, 20'h08); wr(0, 2'd1, 20'hB8); wr(0, 2'd2, 20'd2); wr(0, 2'd3, 20'h051);
    wr(1, 2'd0, 20'h0C); wr(1, 2'd1, 20'hBC); wr(1, 2'd2, 20'd1); wr(1, 2'd3, 20'h051);
    @(negedge clk);
    drq = 2'b11;
    @(negedge clk);
    chk("R7 channel 0 first", bus_addr, 32'h08);
    wait_done(1);
    chk("R7 channel 0 finished before channel 1", 32'(done), 32'b11);
    chk("R7 channel 1 data", 32'(mem[9'h0BC]), 32'(mem[9'h00C]));
    drq = 2'b00;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule